// File: doc/BRIEF.md
# PHY Discovery and Setup Sequencer

This block runs a one-shot bring-up pass over the management bus after a start pulse. It walks every PHY address and reads each responder's status register (register 1). It accepts a responder only when the status bits look like a real transceiver. For each accepted PHY it reads the control register (register 0) and the advertisement register (register 4). It then writes back a corrected advertisement and a corrected control word, but only when the new value differs from what the PHY already holds.

All register traffic goes through a simple request port toward an MDIO master. The block raises a request, holds it steady, and waits for the master's completion before it moves on. The results are a table of up to `N_SLOTS` found addresses, the number found, and a one-cycle done pulse. A per-slot advertisement memory keeps its contents from one run to the next and is cleared only by reset. The configuration inputs must be held steady for the whole run.

Top module: `phy_scan_seq`

## Requirements
- R1: After start, register 1 is read at addresses 1, 2, … 31 and then 0, one address at a time. The scan stops after the address whose processing fills the table. No register-1 read is issued once the count equals `N_SLOTS`.
- R2: A PHY is accepted when (status & 0x8301) == 0x8001, or when status bit 15 is 0 and any of status bits 14:11 is 1. Any other status skips the address.
- R3: For an accepted PHY, register 0 and then register 4 are read. If bits 8:5 of the value read from register 4 are all zero, the read value is replaced by ((status >> 6) & 0x03E0) | 1.
- R4: The advertisement to apply is chosen in a fixed order. The run's working value comes first when it is nonzero; the working value is loaded from `cfg_adv` at start. Next comes the nonzero stored value of the current slot. Otherwise the read value is used. A nonzero working value is copied into the slot store. When both the working value and the stored value are zero, the read value is copied into the slot store and also becomes the working value.
- R5: Register 4 is written with the chosen value only when that value differs from the (possibly replaced) read value.
- R6: The new control word is built in four steps. With `force_media` = 0, bit 12 is set, and bit 9 is set as well when bit 12 was 0. With `force_media` = 1, bit 12 is cleared. Bits 15, 14, 13, 11, 10, 8 and 7 are then cleared. Finally bit 8 takes `full_duplex` and bit 13 takes `speed100`.
- R7: Register 0 is written only when the new control word differs from the value read. When bit 12 changed, the same word is written twice. The completion of the second write comes at least `GAP_CYCLES` cycles after the completion of the first.
- R8: Each accepted PHY's address is stored in slot k = order of acceptance, at bits 5k+4:5k of `found_tbl`. `found_count` gives the number accepted. The table and count are cleared at start.
- R9: When no PHY is accepted and `phy_required` is 1, slot 0 holds address 1 and `found_count` stays 0. When `phy_required` is 0, the table stays all zero.
- R10: `done` is high for exactly one cycle after the last access. A start pulse that arrives during a run has no effect on the access sequence.
- R11: While `req_valid` is high and `req_done` is low, `req_valid`, `req_write`, `req_phy`, `req_reg` and `req_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a discovery pass (ignored while busy) |
| cfg_adv | input | 16 | Configured advertisement, 0 means none |
| force_media | input | 1 | 1: disable auto-negotiation on found PHYs |
| full_duplex | input | 1 | Control-word full-duplex setting |
| speed100 | input | 1 | Control-word 100 Mb/s setting |
| phy_required | input | 1 | Record address 1 when nothing is found |
| req_valid | output | 1 | Register access request |
| req_write | output | 1 | 1 write, 0 read |
| req_phy | output | 5 | Target PHY address |
| req_reg | output | 5 | Target register number |
| req_wdata | output | 16 | Write data |
| req_done | input | 1 | Access complete (one-cycle pulse) |
| req_rdata | input | 16 | Read data, valid with req_done |
| found_tbl | output | 5*N_SLOTS | Found addresses, slot k at bits 5k+4:5k |
| found_count | output | clog2(N_SLOTS+1) | Number of PHYs found |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two functions can land on the same PHY and overlap: the advertisement fix-up and the double control write. The second can also coincide with the moment the table fills, which is the point where the scan must stop. The bench models register contents that mix PHYs whose auto-negotiation enable differs from the requested mode with PHYs whose advertisement needs replacing. Some scenarios fill the table on a PHY that needs both writes. The complete access log is compared entry by entry against a sequence computed in the bench, and the spacing of the paired control writes is measured against the gap.

// File: rtl/phy_scan_seq.sv
module phy_scan_seq #(
  parameter int N_SLOTS    = 4,
  parameter int GAP_CYCLES = 2500
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [15:0]                   cfg_adv,
  input  logic                          force_media,
  input  logic                          full_duplex,
  input  logic                          speed100,
  input  logic                          phy_required,
  output logic                          req_valid,
  output logic                          req_write,
  output logic [4:0]                    req_phy,
  output logic [4:0]                    req_reg,
  output logic [15:0]                   req_wdata,
  input  logic                          req_done,
  input  logic [15:0]                   req_rdata,
  output logic [5*N_SLOTS-1:0]          found_tbl,
  output logic [$clog2(N_SLOTS+1)-1:0]  found_count,
  output logic                          done
);
  localparam int CW = $clog2(N_SLOTS+1);
  localparam int SW = $clog2(N_SLOTS);
  localparam int GW = $clog2(GAP_CYCLES+1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_RCT, S_RAD, S_DEC, S_WAD, S_CHK, S_WC1, S_GAP, S_WC2, S_NXT, S_FIN
  } st_t;

  st_t            state;
  logic [5:0]     idx;
  logic [CW-1:0]  cnt;
  logic [15:0]    st_r, ct_r, ad_r, eff_adv, to_adv, new_ct;
  logic           ane_sw;
  logic [GW-1:0]  gap_cnt;
  logic [15:0]    adv_st [N_SLOTS];

  wire [SW-1:0] slot = cnt[SW-1:0];
  wire          full = (cnt == CW'(N_SLOTS));
  wire          qual = ((req_rdata & 16'h8301) == 16'h8001) ||
                       (!req_rdata[15] && (req_rdata[14:11] != 4'd0));
  wire [15:0]   ad_fix = (req_rdata[8:5] == 4'd0) ? (((st_r >> 6) & 16'h03E0) | 16'h0001)
                                                  : req_rdata;
  wire [15:0]   stored = adv_st[slot];
  wire [15:0]   chosen = (eff_adv != 16'd0) ? eff_adv : ((stored != 16'd0) ? stored : ad_r);
  wire          ane_chg = force_media ? ct_r[12] : !ct_r[12];
  wire [15:0]   ct_base = force_media ? (ct_r & ~16'h1000)
                                      : (ct_r | 16'h1000 | (ane_chg ? 16'h0200 : 16'h0000));
  wire [15:0]   ct_calc = (ct_base & ~16'hED80) | {2'b00, speed100, 4'b0000, full_duplex, 8'h00};

  assign req_valid = (state == S_RST) || (state == S_RCT) || (state == S_RAD) ||
                     (state == S_WAD) || (state == S_WC1) || (state == S_WC2);
  assign req_write = (state == S_WAD) || (state == S_WC1) || (state == S_WC2);
  assign req_phy   = idx[4:0];
  assign req_reg   = (state == S_RST) ? 5'd1 :
                     ((state == S_RAD) || (state == S_WAD)) ? 5'd4 : 5'd0;
  assign req_wdata = (state == S_WAD) ? to_adv : (req_write ? new_ct : 16'd0);
  assign found_count = cnt;

  wire step = req_valid && req_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= 6'd0;
      cnt       <= '0;
      st_r      <= 16'd0;
      ct_r      <= 16'd0;
      ad_r      <= 16'd0;
      eff_adv   <= 16'd0;
      to_adv    <= 16'd0;
      new_ct    <= 16'd0;
      ane_sw    <= 1'b0;
      gap_cnt   <= '0;
      found_tbl <= '0;
      done      <= 1'b0;
      for (int k = 0; k < N_SLOTS; k++) adv_st[k] <= 16'd0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          idx       <= 6'd1;
          cnt       <= '0;
          found_tbl <= '0;
          eff_adv   <= cfg_adv;
          state     <= S_RST;
        end
        S_RST: if (step) begin
          st_r  <= req_rdata;
          state <= qual ? S_RCT : S_NXT;
        end
        S_RCT: if (step) begin
          ct_r  <= req_rdata;
          state <= S_RAD;
        end
        S_RAD: if (step) begin
          ad_r  <= ad_fix;
          state <= S_DEC;
        end
        S_DEC: begin
          if (eff_adv != 16'd0) adv_st[slot] <= eff_adv;
          else if (stored == 16'd0) begin
            adv_st[slot] <= ad_r;
            eff_adv      <= ad_r;
          end
          to_adv <= chosen;
          new_ct <= ct_calc;
          ane_sw <= ane_chg;
          found_tbl[slot*5 +: 5] <= idx[4:0];
          cnt   <= cnt + 1'b1;
          state <= (chosen != ad_r) ? S_WAD : S_CHK;
        end
        S_WAD: if (step) state <= S_CHK;
        S_CHK: state <= (new_ct == ct_r) ? S_NXT : (ane_sw ? S_WC1 : S_WC2);
        S_WC1: if (step) begin
          gap_cnt <= GW'(GAP_CYCLES);
          state   <= S_GAP;
        end
        S_GAP: if (gap_cnt == '0) state <= S_WC2;
               else gap_cnt <= gap_cnt - 1'b1;
        S_WC2: if (step) state <= S_NXT;
        S_NXT: begin
          if (idx == 6'd32 || full) state <= S_FIN;
          else begin
            idx   <= idx + 6'd1;
            state <= S_RST;
          end
        end
        S_FIN: begin
          if (cnt == '0 && phy_required) found_tbl[4:0] <= 5'd1;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_done) |=> (req_valid && $stable(req_write) && $stable(req_phy) &&
                                  $stable(req_reg) && $stable(req_wdata)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    found_count <= CW'(N_SLOTS));

  a_r1_no_scan_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_reg == 5'd1) |-> (found_count < CW'(N_SLOTS)));

  a_r5_adv_write_differs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_reg == 5'd4) |-> (req_wdata != ad_r));

  a_r7_ctl_write_differs: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_reg == 5'd0) |-> (req_wdata != ct_r));
endmodule

// File: tb/test_phy_scan_seq.sv
module test_phy_scan_seq;
  localparam int N   = 4;
  localparam int GAP = 20;
  localparam int CW  = $clog2(N+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] cfg_adv = 16'd0;
  logic force_media = 1'b0, full_duplex = 1'b0, speed100 = 1'b0, phy_required = 1'b0;
  logic req_valid, req_write, done;
  logic [4:0] req_phy, req_reg;
  logic [15:0] req_wdata;
  logic req_done = 1'b0;
  logic [15:0] req_rdata = 16'd0;
  logic [5*N-1:0] found_tbl;
  logic [CW-1:0] found_count;

  always #2 clk = ~clk;

  phy_scan_seq #(.N_SLOTS(N), .GAP_CYCLES(GAP)) i_phy_scan_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_adv(cfg_adv),
    .force_media(force_media), .full_duplex(full_duplex), .speed100(speed100),
    .phy_required(phy_required), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata), .found_tbl(found_tbl),
    .found_count(found_count), .done(done));

  int checks = 0, fails = 0;
  int cur_sc = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] m_st(int sc, int a);
    if (sc == 0) return 16'hFFFF;
    if (sc == 1) return (a == 31) ? 16'h7849 : ((a == 0) ? 16'h8001 : 16'h0009);
    case ((a * (sc + 2) + sc) % 6)
      0: return 16'hFFFF;
      1: return 16'h7849;
      2: return 16'h8001;
      3: return 16'h0009;
      4: return 16'h8301;
      default: return 16'h0800;
    endcase
  endfunction
  function automatic logic [15:0] m_ct(int sc, int a);
    return 16'(a * 16'h1357 + sc * 16'h2468 + 16'h0101);
  endfunction
  function automatic logic [15:0] m_ad(int sc, int a);
    if ((a + sc) % 3 == 0) return 16'h0000;
    return 16'(a * 16'h0421 + sc * 16'h0033);
  endfunction

  // responder and access log
  int nlog = 0, lat = 0;
  logic        lw [0:255];
  logic [4:0]  lreg [0:255];
  logic [4:0]  lphy [0:255];
  logic [15:0] ldat [0:255];
  int          lcyc [0:255];
  always @(posedge clk) begin
    req_done <= 1'b0;
    if (req_valid && !req_done) begin
      if (lat == 2) begin
        lat <= 0;
        req_done <= 1'b1;
        req_rdata <= (req_reg == 5'd1) ? m_st(cur_sc, req_phy) :
                     (req_reg == 5'd0) ? m_ct(cur_sc, req_phy) :
                     (req_reg == 5'd4) ? m_ad(cur_sc, req_phy) : 16'd0;
        if (nlog < 256) begin
          lw[nlog] <= req_write; lreg[nlog] <= req_reg; lphy[nlog] <= req_phy;
          ldat[nlog] <= req_wdata; lcyc[nlog] <= cyc;
        end
        nlog <= nlog + 1;
      end else lat <= lat + 1;
    end
  end

  // expected model
  logic [15:0] bstore [N];
  int nexp;
  logic        ew [0:255];
  logic [4:0]  ereg [0:255];
  logic [4:0]  ephy [0:255];
  logic [15:0] edat [0:255];
  logic        egap [0:255];
  logic [4:0]  etbl [N];
  int          ecnt;

  task automatic push(logic w, logic [4:0] r, logic [4:0] a, logic [15:0] d, logic g);
    ew[nexp] = w; ereg[nexp] = r; ephy[nexp] = a; edat[nexp] = d; egap[nexp] = g;
    nexp++;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic build(int sc, logic [15:0] cfg, logic fm, logic fd, logic sp, logic rq);
    logic [15:0] eff, s, c, d, to, nc, b;
    logic sw;
    eff = cfg; nexp = 0; ecnt = 0;
    for (int k = 0; k < N; k++) etbl[k] = 5'd0;
    for (int i = 1; i <= 32; i++) begin
      logic [4:0] a;
      a = 5'(i & 31);
      push(1'b0, 5'd1, a, 16'd0, 1'b0);                 // R1 scan order
      s = m_st(sc, a);
      if (!(((s & 16'h8301) == 16'h8001) || (!s[15] && s[14:11] != 0))) continue; // R2
      c = m_ct(sc, a); push(1'b0, 5'd0, a, 16'd0, 1'b0);
      d = m_ad(sc, a); push(1'b0, 5'd4, a, 16'd0, 1'b0);
      if (d[8:5] == 0) d = ((s >> 6) & 16'h03E0) | 16'h0001; // R3 fallback
      if (eff != 0) begin to = eff; bstore[ecnt] = eff; end   // R4 order
      else if (bstore[ecnt] != 0) to = bstore[ecnt];
      else begin to = d; bstore[ecnt] = d; eff = d; end
      etbl[ecnt] = a; ecnt++;
      if (to != d) push(1'b1, 5'd4, a, to, 1'b0);           // R5
      sw = fm ? c[12] : !c[12];                              // R6
      b = fm ? (c & ~16'h1000) : (c | 16'h1000 | (sw ? 16'h0200 : 16'h0));
      nc = (b & ~16'hED80) | (sp ? 16'h2000 : 16'h0) | (fd ? 16'h0100 : 16'h0);
      if (nc != c) begin                                     // R7
        if (sw) push(1'b1, 5'd0, a, nc, 1'b0);
        push(1'b1, 5'd0, a, nc, sw);
      end
      if (ecnt == N) break;
    end
    if (ecnt == 0 && rq) etbl[0] = 5'd1;                     // R9
  endtask

  task automatic run(int sc, logic [15:0] cfg, logic fm, logic fd, logic sp, logic rq);
    int t;
    build(sc, cfg, fm, fd, sp, rq);
    @(negedge clk);
    cur_sc = sc; cfg_adv = cfg; force_media = fm; full_duplex = fd; speed100 = sp;
    phy_required = rq; nlog = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;            // R10 start while busy
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    check(done == 1'b1, "R10", "done seen", done, 1);
    if (!done) return;
    @(negedge clk);
    check(done == 1'b0, "R10", "done width", done, 0);
    repeat (5) @(negedge clk);
    check(req_valid == 1'b0, "R10", "quiet after done", req_valid, 0);
    check(nlog == nexp, "R1", "access count", nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      check(lw[i] == ew[i] && lreg[i] == ereg[i] && lphy[i] == ephy[i], "R1",
            $sformatf("access %0d kind/reg/phy", i),
            {lw[i], 3'b0, lreg[i], 3'b0, lphy[i]}, {ew[i], 3'b0, ereg[i], 3'b0, ephy[i]});
      if (ew[i]) check(ldat[i] == edat[i], (ereg[i] == 5'd4) ? "R4" : "R6",
                       $sformatf("access %0d data", i), ldat[i], edat[i]);
      if (egap[i] && i > 0)
        check(lcyc[i] - lcyc[i-1] >= GAP, "R7", "double write gap", lcyc[i] - lcyc[i-1], GAP);
    end
    check(found_count == CW'(ecnt), "R8", "count", found_count, ecnt);
    for (int k = 0; k < N; k++)
      check(found_tbl[k*5 +: 5] == etbl[k], (ecnt == 0) ? "R9" : "R8",
            $sformatf("slot %0d", k), found_tbl[k*5 +: 5], etbl[k]);
  endtask

  initial begin
    for (int k = 0; k < N; k++) bstore[k] = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_valid == 0 && done == 0, "R10", "reset outputs", {req_valid, done}, 0);
    check(found_count == 0 && found_tbl == 0, "R8", "reset table", found_tbl, 0);
    run(0, 16'h0000, 0, 0, 0, 1);   // R9 default entry
    run(0, 16'h0000, 0, 0, 0, 0);   // R9 no default
    run(1, 16'h0000, 0, 1, 1, 1);   // R1 address 0 last
    run(2, 16'h01E1, 0, 0, 1, 0);   // R4 configured value
    run(3, 16'h0000, 1, 1, 1, 0);   // R4 stored from read
    run(3, 16'h0000, 0, 0, 0, 0);   // R4 stored persists
    run(4, 16'h0000, 1, 0, 0, 0);
    run(5, 16'h05E1, 0, 1, 0, 0);
    run(7, 16'h0000, 0, 1, 1, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule